// File: doc/BRIEF.md
# Sleep Mode Clock Controller

This block puts a small microcontroller into one of its low-power modes and brings it back out. When the core reports that a sleep instruction has just executed, the controller samples the sleep-enable bit and a 3-bit mode code. If the request is valid, it drops the clock enables for the domains that the chosen mode stops. The domains are the CPU, the program flash, the I/O peripherals, the ADC and the asynchronous logic. The controller also drives the main oscillator enable. On entry to the two lighter modes it can fire a one-cycle request that starts an ADC conversion.

While asleep, the controller watches a vector of wake events that the interrupt logic has already qualified. A mask chosen by the sleep mode decides which events end the sleep. Leaving the deepest mode, where the oscillator was off, first runs a programmable start-up count with the oscillator on and every gated clock still off. All clocks come back together when that count expires. A reset request from any source overrides all of this and restores every clock on the next edge. The sleep-enable bit is an input, and the controller never changes it.

Top module: `sleep_clk_ctrl`

## Requirements
- R1: A pulse on `sleep_exec` while `sleep_en` is 0 has no effect. All six enables stay 1 and `adc_start` stays 0.
- R2: Mode code 3'b000 (idle) leaves CPU and flash enables at 0, with I/O, ADC, asynchronous and oscillator enables at 1, from the edge that samples the request.
- R3: Mode code 3'b001 (ADC quiet) leaves CPU, flash and I/O enables at 0, with ADC, asynchronous and oscillator enables at 1.
- R4: Mode code 3'b010 (power-down) sets all five clock enables and the oscillator enable to 0.
- R5: Mode code 3'b110 (standby) sets all five clock enables to 0 and keeps the oscillator enable at 1.
- R6: Mode codes 3'b011, 3'b100, 3'b101 and 3'b111 are not implemented. A request with any of them is ignored in the same way as in R1.
- R7: `adc_start` is 1 for exactly one cycle, in the cycle the enables first change, when idle or ADC quiet is entered with `adc_enabled` at 1. In every other case it stays 0.
- R8: The wake vector bits are: 0 ADC done, 1 watchdog interrupt, 2 two-wire address match, 3 timer 2 interrupt, 4 non-volatile memory ready, 5 external level interrupt, 6 pin change, 7 any other interrupt. In idle, any of the eight bits restores all enables on the edge that samples it.
- R9: In ADC quiet, bits 0 to 6 wake the system and bit 7 has no effect.
- R10: In power-down and standby, only bits 1, 2, 5 and 6 wake the system. The other bits have no effect.
- R11: A wake from standby restores all enables on the sampling edge. A wake from power-down first sets only the oscillator enable to 1. All clocks then return N+1 cycles after the sampling edge, where N is `osc_start_cycles`.
- R12: `reset_req` restores all six enables on the next edge from any state, including start-up. It also takes priority over a sleep request in the same cycle.
- R13: After `rst_n` is released, all six enables are 1 and `adc_start` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_exec | input | 1 | One-cycle pulse: the core executed a sleep instruction |
| sleep_en | input | 1 | Software sleep-enable bit |
| mode_sel | input | 3 | Sleep mode code |
| adc_enabled | input | 1 | ADC is switched on by software |
| wake_evt | input | 8 | Qualified wake events, bit meaning as in R8 |
| reset_req | input | 1 | Any reset source (external, watchdog, brown-out) |
| osc_start_cycles | input | CNT_W | Oscillator start-up delay in cycles |
| clk_en_cpu | output | 1 | CPU clock enable |
| clk_en_flash | output | 1 | Flash clock enable |
| clk_en_io | output | 1 | I/O clock enable |
| clk_en_adc | output | 1 | ADC clock enable |
| clk_en_async | output | 1 | Asynchronous domain clock enable |
| osc_en | output | 1 | Main oscillator enable |
| adc_start | output | 1 | One-cycle ADC conversion start request |

## Verification
The bench walks every mode code with both values of the enable bit and the ADC switch. A decoder that treated an unused code as a real mode would gate clocks that must stay on. A missing enable-bit check would put the core to sleep anyway. It then raises each wake bit on its own in every implemented mode. A wrong mask would either leave the system asleep when it should wake, or wake it on an event such as bit 7 in ADC quiet. The start-up delay is swept over several lengths, including zero, and is checked on both sides of the edge where the clocks return. An off-by-one counter would restore the clocks one cycle early or late. A reset during start-up and a reset that coincides with a sleep request catch a design that lets the delay or the request win over reset.

// File: rtl/slp_pkg.sv
package slp_pkg;

    localparam int MODE_W = 3;
    localparam int WAKE_W = 8;

    // mode codes (the encoding is behaviour: software writes these)
    localparam logic [MODE_W-1:0] CODE_IDLE  = 3'b000;
    localparam logic [MODE_W-1:0] CODE_QUIET = 3'b001;
    localparam logic [MODE_W-1:0] CODE_PDOWN = 3'b010;
    localparam logic [MODE_W-1:0] CODE_STBY  = 3'b110;

    // wake vector bit positions
    localparam int WK_ADC_DONE = 0;
    localparam int WK_WDT_IRQ  = 1;
    localparam int WK_TWI_ADDR = 2;
    localparam int WK_TMR2     = 3;
    localparam int WK_NVM_RDY  = 4;
    localparam int WK_EXT_LVL  = 5;
    localparam int WK_PIN_CHG  = 6;
    localparam int WK_OTHER    = 7;

    typedef struct packed {
        logic cpu;
        logic flash;
        logic io;
        logic adc;
        logic asyn;
        logic osc;
    } clk_en_t;

    localparam clk_en_t EN_ALL  = '{cpu: 1'b1, flash: 1'b1, io: 1'b1, adc: 1'b1, asyn: 1'b1, osc: 1'b1};
    localparam clk_en_t EN_WARM = '{cpu: 1'b0, flash: 1'b0, io: 1'b0, adc: 1'b0, asyn: 1'b0, osc: 1'b1};

    typedef struct packed {
        logic              valid;
        clk_en_t           en;
        logic [WAKE_W-1:0] mask;
        logic              adc_kick;
        logic              needs_warm;
    } profile_t;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_SLEEP,
        ST_WARM
    } state_t;

endpackage

// File: rtl/slp_mode_decode.sv
module slp_mode_decode
    import slp_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    output profile_t          prof_o
);

    localparam logic [WAKE_W-1:0] MASK_ANY = '1;
    localparam logic [WAKE_W-1:0] MASK_QUIET = MASK_ANY & ~(WAKE_W'(1) << WK_OTHER);
    localparam logic [WAKE_W-1:0] MASK_DEEP =
        (WAKE_W'(1) << WK_WDT_IRQ) | (WAKE_W'(1) << WK_TWI_ADDR) |
        (WAKE_W'(1) << WK_EXT_LVL) | (WAKE_W'(1) << WK_PIN_CHG);

    always_comb begin
        prof_o            = '0;
        prof_o.en         = EN_ALL;
        case (mode_i)
            CODE_IDLE: begin
                prof_o.valid    = 1'b1;
                prof_o.en       = '{cpu: 1'b0, flash: 1'b0, io: 1'b1, adc: 1'b1, asyn: 1'b1, osc: 1'b1};
                prof_o.mask     = MASK_ANY;
                prof_o.adc_kick = 1'b1;
            end
            CODE_QUIET: begin
                prof_o.valid    = 1'b1;
                prof_o.en       = '{cpu: 1'b0, flash: 1'b0, io: 1'b0, adc: 1'b1, asyn: 1'b1, osc: 1'b1};
                prof_o.mask     = MASK_QUIET;
                prof_o.adc_kick = 1'b1;
            end
            CODE_PDOWN: begin
                prof_o.valid      = 1'b1;
                prof_o.en         = '0;
                prof_o.mask       = MASK_DEEP;
                prof_o.needs_warm = 1'b1;
            end
            CODE_STBY: begin
                prof_o.valid = 1'b1;
                prof_o.en    = EN_WARM;
                prof_o.mask  = MASK_DEEP;
            end
            default: begin
                prof_o.valid = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/slp_warmup_timer.sv
module slp_warmup_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = (cnt_q == '0);

    // R11: once drained, the count stays drained until reloaded
    a_r11_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (expired_o && !load_i) |=> expired_o);

endmodule

// File: rtl/sleep_clk_ctrl.sv
module sleep_clk_ctrl
    import slp_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_exec,
    input  logic             sleep_en,
    input  logic [2:0]       mode_sel,
    input  logic             adc_enabled,
    input  logic [7:0]       wake_evt,
    input  logic             reset_req,
    input  logic [CNT_W-1:0] osc_start_cycles,
    output logic             clk_en_cpu,
    output logic             clk_en_flash,
    output logic             clk_en_io,
    output logic             clk_en_adc,
    output logic             clk_en_async,
    output logic             osc_en,
    output logic             adc_start
);

    typedef struct packed {
        state_t            state;
        clk_en_t           en;
        logic [WAKE_W-1:0] mask;
        logic              warm;
        logic              adc_start;
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{state: ST_RUN, en: EN_ALL, mask: '0, warm: 1'b0, adc_start: 1'b0};

    ctrl_t    ctrl_d, ctrl_q;
    profile_t prof;
    logic     wake_hit;
    logic     tmr_load;
    logic     tmr_expired;

    slp_mode_decode i_decode (
        .mode_i (mode_sel),
        .prof_o (prof)
    );

    slp_warmup_timer #(.CNT_W(CNT_W)) i_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (osc_start_cycles),
        .expired_o  (tmr_expired)
    );

    assign wake_hit = |(wake_evt & ctrl_q.mask);
    assign tmr_load = !reset_req && (ctrl_q.state == ST_SLEEP) && wake_hit && ctrl_q.warm;

    always_comb begin
        ctrl_d           = ctrl_q;
        ctrl_d.adc_start = 1'b0;
        if (reset_req) begin
            ctrl_d.state = ST_RUN;
            ctrl_d.en    = EN_ALL;
        end else begin
            case (ctrl_q.state)
                ST_RUN: begin
                    if (sleep_exec && sleep_en && prof.valid) begin
                        ctrl_d.state     = ST_SLEEP;
                        ctrl_d.en        = prof.en;
                        ctrl_d.mask      = prof.mask;
                        ctrl_d.warm      = prof.needs_warm;
                        ctrl_d.adc_start = prof.adc_kick && adc_enabled;
                    end
                end
                ST_SLEEP: begin
                    if (wake_hit) begin
                        if (ctrl_q.warm) begin
                            ctrl_d.state = ST_WARM;
                            ctrl_d.en    = EN_WARM;
                        end else begin
                            ctrl_d.state = ST_RUN;
                            ctrl_d.en    = EN_ALL;
                        end
                    end
                end
                ST_WARM: begin
                    if (tmr_expired) begin
                        ctrl_d.state = ST_RUN;
                        ctrl_d.en    = EN_ALL;
                    end
                end
                default: begin
                    ctrl_d.state = ST_RUN;
                    ctrl_d.en    = EN_ALL;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign clk_en_cpu   = ctrl_q.en.cpu;
    assign clk_en_flash = ctrl_q.en.flash;
    assign clk_en_io    = ctrl_q.en.io;
    assign clk_en_adc   = ctrl_q.en.adc;
    assign clk_en_async = ctrl_q.en.asyn;
    assign osc_en       = ctrl_q.en.osc;
    assign adc_start    = ctrl_q.adc_start;

    // R1: a request without the enable bit keeps the core clocked
    a_r1_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en_cpu && sleep_exec && !sleep_en) |=> clk_en_cpu);

    // R7: the conversion start is a single-cycle pulse
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start);

    // R7: the pulse only accompanies the CPU clock going away
    a_r7_only_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> (!clk_en_cpu && clk_en_adc));

    // R12: a reset request brings every enable back on the next edge
    a_r12_reset_restores: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> (clk_en_cpu && clk_en_flash && clk_en_io &&
                       clk_en_adc && clk_en_async && osc_en));

    // R11: with the oscillator off, the CPU clock cannot return without a start-up phase
    a_r11_warm_first: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_en && !reset_req) |=> !clk_en_cpu);

    // R4: oscillator off implies the peripheral clocks are off too
    a_r4_deep_all_off: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> (!clk_en_io && !clk_en_adc && !clk_en_async));

endmodule

// File: tb/test_sleep_clk_ctrl.sv
module test_sleep_clk_ctrl;

    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sleep_exec = 1'b0;
    logic             sleep_en = 1'b0;
    logic [2:0]       mode_sel = 3'b000;
    logic             adc_enabled = 1'b0;
    logic [7:0]       wake_evt = 8'h00;
    logic             reset_req = 1'b0;
    logic [CNT_W-1:0] osc_start_cycles = '0;
    logic             clk_en_cpu, clk_en_flash, clk_en_io, clk_en_adc, clk_en_async, osc_en, adc_start;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    sleep_clk_ctrl #(.CNT_W(CNT_W)) i_sleep_clk_ctrl (
        .clk              (clk),
        .rst_n            (rst_n),
        .sleep_exec       (sleep_exec),
        .sleep_en         (sleep_en),
        .mode_sel         (mode_sel),
        .adc_enabled      (adc_enabled),
        .wake_evt         (wake_evt),
        .reset_req        (reset_req),
        .osc_start_cycles (osc_start_cycles),
        .clk_en_cpu       (clk_en_cpu),
        .clk_en_flash     (clk_en_flash),
        .clk_en_io        (clk_en_io),
        .clk_en_adc       (clk_en_adc),
        .clk_en_async     (clk_en_async),
        .osc_en           (osc_en),
        .adc_start        (adc_start)
    );

    always #5 clk = ~clk;

    // enables packed as {cpu, flash, io, adc, async, osc}
    function automatic logic [5:0] get_en();
        return {clk_en_cpu, clk_en_flash, clk_en_io, clk_en_adc, clk_en_async, osc_en};
    endfunction

    function automatic bit implemented(input logic [2:0] m);
        return (m == 3'b000) || (m == 3'b001) || (m == 3'b010) || (m == 3'b110);
    endfunction

    function automatic logic [5:0] exp_sleep_en(input logic [2:0] m);
        case (m)
            3'b000:  return 6'b001111;
            3'b001:  return 6'b000111;
            3'b010:  return 6'b000000;
            3'b110:  return 6'b000001;
            default: return 6'b111111;
        endcase
    endfunction

    function automatic bit wake_allowed(input logic [2:0] m, input int b);
        case (m)
            3'b000:  return 1'b1;
            3'b001:  return b != 7;
            default: return (b == 1) || (b == 2) || (b == 5) || (b == 6);
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic request(input logic [2:0] m, input logic se, input logic adc);
        mode_sel    = m;
        sleep_en    = se;
        adc_enabled = adc;
        sleep_exec  = 1'b1;
        step();
        sleep_exec  = 1'b0;
        sleep_en    = 1'b0;
    endtask

    task automatic recover();
        reset_req = 1'b1;
        step();
        reset_req = 1'b0;
        check("R12 reset restores", {2'b00, get_en()}, 8'h3f);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        check("R13 reset enables", {2'b00, get_en()}, 8'h3f);
        check("R13 reset adc_start", {7'd0, adc_start}, 8'h00);

        // every mode code, enable bit and ADC switch
        for (int m = 0; m < 8; m++) begin
            for (int se = 0; se < 2; se++) begin
                for (int a = 0; a < 2; a++) begin
                    logic [2:0] mc;
                    bit         goes;
                    mc   = 3'(m);
                    goes = (se == 1) && implemented(mc);
                    request(mc, 1'(se), 1'(a));
                    if (!goes) begin
                        check(se == 0 ? "R1 ignored request" : "R6 unused code", {2'b00, get_en()}, 8'h3f);
                    end else begin
                        case (mc)
                            3'b000:  check("R2 idle enables", {2'b00, get_en()}, {2'b00, exp_sleep_en(mc)});
                            3'b001:  check("R3 quiet enables", {2'b00, get_en()}, {2'b00, exp_sleep_en(mc)});
                            3'b010:  check("R4 power-down enables", {2'b00, get_en()}, {2'b00, exp_sleep_en(mc)});
                            default: check("R5 standby enables", {2'b00, get_en()}, {2'b00, exp_sleep_en(mc)});
                        endcase
                    end
                    check("R7 start pulse", {7'd0, adc_start},
                          {7'd0, 1'(goes && (a == 1) && (mc == 3'b000 || mc == 3'b001))});
                    step();
                    check("R7 pulse ends", {7'd0, adc_start}, 8'h00);
                    if (goes) recover();
                end
            end
        end

        // each wake bit alone in each implemented mode
        osc_start_cycles = 8'd2;
        for (int mi = 0; mi < 4; mi++) begin
            logic [2:0] mc;
            mc = (mi == 0) ? 3'b000 : (mi == 1) ? 3'b001 : (mi == 2) ? 3'b010 : 3'b110;
            for (int b = 0; b < 8; b++) begin
                string tag;
                tag = (mc == 3'b000) ? "R8 idle wake" : (mc == 3'b001) ? "R9 quiet wake" : "R10 deep wake";
                request(mc, 1'b1, 1'b0);
                wake_evt = 8'(1 << b);
                step();
                wake_evt = 8'h00;
                if (!wake_allowed(mc, b)) begin
                    check(tag, {2'b00, get_en()}, {2'b00, exp_sleep_en(mc)});
                    step();
                    check(tag, {2'b00, get_en()}, {2'b00, exp_sleep_en(mc)});
                    recover();
                end else if (mc == 3'b010) begin
                    check("R11 start-up phase", {2'b00, get_en()}, 8'h01);
                    step();
                    step();
                    check("R11 still starting", {2'b00, get_en()}, 8'h01);
                    step();
                    check(tag, {2'b00, get_en()}, 8'h3f);
                end else begin
                    check(mc == 3'b110 ? "R11 standby fast wake" : tag, {2'b00, get_en()}, 8'h3f);
                end
            end
        end

        // start-up delay lengths
        for (int i = 0; i < 5; i++) begin
            int n;
            n = (i == 0) ? 0 : (i == 1) ? 1 : (i == 2) ? 3 : (i == 3) ? 9 : 20;
            osc_start_cycles = 8'(n);
            request(3'b010, 1'b1, 1'b1);
            check("R7 no pulse in power-down", {7'd0, adc_start}, 8'h00);
            wake_evt = 8'h40;
            step();
            wake_evt = 8'h00;
            check("R11 start-up entered", {2'b00, get_en()}, 8'h01);
            for (int k = 0; k < n; k++) step();
            check("R11 clocks held until expiry", {2'b00, get_en()}, 8'h01);
            step();
            check("R11 clocks restored", {2'b00, get_en()}, 8'h3f);
        end

        // reset during start-up
        osc_start_cycles = 8'd9;
        request(3'b010, 1'b1, 1'b0);
        wake_evt = 8'h02;
        step();
        wake_evt = 8'h00;
        step();
        recover();

        // reset in each sleep mode, no start-up from power-down
        for (int mi = 0; mi < 4; mi++) begin
            logic [2:0] mc;
            mc = (mi == 0) ? 3'b000 : (mi == 1) ? 3'b001 : (mi == 2) ? 3'b010 : 3'b110;
            request(mc, 1'b1, 1'b0);
            recover();
            step();
            check("R12 stays awake", {2'b00, get_en()}, 8'h3f);
        end

        // reset wins over a simultaneous sleep request
        reset_req   = 1'b1;
        mode_sel    = 3'b010;
        sleep_en    = 1'b1;
        adc_enabled = 1'b1;
        sleep_exec  = 1'b1;
        step();
        reset_req  = 1'b0;
        sleep_exec = 1'b0;
        sleep_en   = 1'b0;
        check("R12 reset over sleep", {2'b00, get_en()}, 8'h3f);

        // wake events while running do nothing
        wake_evt = 8'hff;
        step();
        wake_evt = 8'h00;
        check("R1 running unaffected", {1'b0, adc_start, get_en()}, 8'h3f);

        finish_run();
    end

endmodule